// File: doc/BRIEF.md
# Trace and Floating-Point Assist Exception Entry

This block sits beside a processor's sequencer and decides, every cycle, whether a single-step trace exception or a floating-point assist exception must be taken. It watches the current machine state word, the floating-point enable and summary flags, a tiny-result flag, a single-step completion strobe and the current and next instruction addresses. When it takes an exception, it registers the state save and the new machine state in one clock edge. On that same edge it raises a one-cycle redirect strobe together with the handler address.

A floating-point condition that was produced by a register move or by a return from interrupt is not an assist case. The block signals a program exception request for it instead and leaves its saved state untouched. On entry, the new machine state takes its endianness from the interrupt-endian field. Its compression-enable bit is derived from two bits of an external compression-control register.

Bit numbering below is little-endian (bit 0 is the least significant). The machine state fields the block uses are at these positions:

| Field | Bit |
|-------|-----|
| LE (little-endian) | 0 |
| IP (vector base select) | 6 |
| FE1 | 8 |
| FE0 | 11 |
| ME | 12 |
| ILE | 16 |
| CMPEN (compression enable) | 30 |

Top module: `exc_entry_ctl`

## Requirements
- R1: A synchronous reset clears `msr_o`, `srr0_o`, `srr1_o` and `vec_o` to zero, and deasserts `redirect_o` and `prog_req_o`.
- R2: The FP-enabled condition is (`msr_i[11]` OR `msr_i[8]`) AND `fex_i`. When this condition holds and `fp_from_move_i` is 0, an assist exception is taken. The next cycle shows `redirect_o`=1, `vec_o`=base|0x0E00 and `srr0_o`=`pc_cur_i`.
- R3: When the FP-enabled condition holds and `fp_from_move_i` is 1, `prog_req_o` is 1 in the next cycle. No exception is taken in that case, whatever `tiny_i` and `step_i` are: `redirect_o` stays 0 and `msr_o`, `srr0_o`, `srr1_o` and `vec_o` keep their values.
- R4: An assist exception is also taken when `tiny_i`=1 and `ue_i`=0, provided R3 does not apply.
- R5: When `step_i`=1 and no assist or program case applies, a trace exception is taken. The next cycle shows `redirect_o`=1, `vec_o`=base|0x0D00 and `srr0_o`=`pc_next_i`.
- R6: If a trace and an assist exception are both requested in the same cycle, only the assist exception is taken.
- R7: The vector base is 0x00000000 when `msr_i[6]`=0 and 0xFFF00000 when `msr_i[6]`=1.
- R8: On entry, `srr1_o[15:0]` is loaded from `msr_i[15:0]`. Bits [30:27] and [21:16] are cleared, and bits 31 and [26:22] keep their previous value.
- R9: On entry, `msr_o[0]` is loaded from `msr_i[16]`, and bits 12 and 6 are copied from `msr_i`. Bit 30 is set to `cmp_en_i` AND `cmp_exc_i`, and every other bit is cleared.
- R10: `redirect_o` is high for exactly one cycle per exception taken. When no exception is taken, `msr_o`, `srr0_o`, `srr1_o` and `vec_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msr_i | input | 32 | Current machine state word |
| fex_i | input | 1 | Floating-point enabled-exception summary flag |
| ue_i | input | 1 | Underflow enable |
| tiny_i | input | 1 | Tiny result detected this cycle |
| fp_from_move_i | input | 1 | FP condition arose from a register move or a return from interrupt |
| step_i | input | 1 | Single-step instruction completion strobe |
| cmp_en_i | input | 1 | Compression-control enable bit |
| cmp_exc_i | input | 1 | Compression-control exception-mode bit |
| pc_cur_i | input | 32 | Address of the instruction that raised the FP condition |
| pc_next_i | input | 32 | Address of the instruction after the one just executed |
| msr_o | output | 32 | Machine state word written on exception entry |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state word |
| redirect_o | output | 1 | One-cycle strobe: fetch from `vec_o` |
| vec_o | output | 32 | Handler address |
| prog_req_o | output | 1 | Program exception request |

## Verification
The assertions rely on two things about the inputs: reset is held high from time zero until the first edges have passed, and the inputs carry defined values at every rising clock edge. With those in place, the rules for priority and for held state can be checked on the registered outputs alone. The bench meets both conditions. It drives every input on the falling edge and keeps reset high for several cycles at the start. It sweeps all 1024 combinations of the ten control bits, with the machine state word and addresses derived from the sweep index. An idle cycle follows each combination, so the held-state rule is checked after every exception and after every program request.

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl #(
  parameter int          AW         = 32,
  parameter logic [31:0] TRACE_OFS  = 32'h0000_0D00,
  parameter logic [31:0] ASSIST_OFS = 32'h0000_0E00,
  parameter logic [31:0] HI_BASE    = 32'hFFF0_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   msr_i,
  input  logic          fex_i,
  input  logic          ue_i,
  input  logic          tiny_i,
  input  logic          fp_from_move_i,
  input  logic          step_i,
  input  logic          cmp_en_i,
  input  logic          cmp_exc_i,
  input  logic [AW-1:0] pc_cur_i,
  input  logic [AW-1:0] pc_next_i,
  output logic [31:0]   msr_o,
  output logic [AW-1:0] srr0_o,
  output logic [31:0]   srr1_o,
  output logic          redirect_o,
  output logic [31:0]   vec_o,
  output logic          prog_req_o
);
  localparam int B_LE  = 0;
  localparam int B_IP  = 6;
  localparam int B_FE1 = 8;
  localparam int B_FE0 = 11;
  localparam int B_ME  = 12;
  localparam int B_ILE = 16;
  localparam int B_CMP = 30;
  localparam logic [31:0] KEEP = (32'h1 << B_LE) | (32'h1 << B_IP) |
                                 (32'h1 << B_ME) | (32'h1 << B_CMP);

  logic fp_cond, prog_c, assist_c, trace_c, take;
  logic [31:0] base, vec_n, msr_n, srr1_n;
  logic [AW-1:0] srr0_n;

  assign fp_cond  = (msr_i[B_FE0] | msr_i[B_FE1]) & fex_i;
  assign prog_c   = fp_cond & fp_from_move_i;
  assign assist_c = ~prog_c & (fp_cond | (tiny_i & ~ue_i));
  assign trace_c  = ~prog_c & ~assist_c & step_i;
  assign take     = assist_c | trace_c;

  assign base  = msr_i[B_IP] ? HI_BASE : 32'h0;
  assign vec_n = base | (assist_c ? ASSIST_OFS : TRACE_OFS);
  assign srr0_n = assist_c ? pc_cur_i : pc_next_i;

  always_comb begin
    msr_n        = '0;
    msr_n[B_LE]  = msr_i[B_ILE];
    msr_n[B_IP]  = msr_i[B_IP];
    msr_n[B_ME]  = msr_i[B_ME];
    msr_n[B_CMP] = cmp_en_i & cmp_exc_i;
  end

  assign srr1_n = {srr1_o[31], 4'b0000, srr1_o[26:22], 6'b000000, msr_i[15:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_o      <= '0;
      srr0_o     <= '0;
      srr1_o     <= '0;
      vec_o      <= '0;
      redirect_o <= 1'b0;
      prog_req_o <= 1'b0;
    end else begin
      redirect_o <= take;
      prog_req_o <= prog_c;
      if (take) begin
        msr_o  <= msr_n;
        srr0_o <= srr0_n;
        srr1_o <= srr1_n;
        vec_o  <= vec_n;
      end
    end
  end

  p_prog_no_entry_r3: assert property (@(posedge clk) disable iff (rst)
    prog_req_o |-> !redirect_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !redirect_o |-> (msr_o == $past(msr_o)) && (srr0_o == $past(srr0_o)) &&
                    (srr1_o == $past(srr1_o)) && (vec_o == $past(vec_o)));

  p_vec_shape_r7: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (vec_o[31:20] == 12'h000 || vec_o[31:20] == 12'hFFF) &&
                   (vec_o[19:0] == TRACE_OFS[19:0] || vec_o[19:0] == ASSIST_OFS[19:0]));

  p_msr_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (msr_o & ~KEEP) == 32'h0);

  p_srr1_zero_r8: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> srr1_o[30:27] == 4'h0 && srr1_o[21:16] == 6'h0);

  p_trace_prio_r6: assert property (@(posedge clk) disable iff (rst)
    redirect_o && vec_o[19:0] == TRACE_OFS[19:0] |->
      $past(step_i) && !($past(tiny_i) && !$past(ue_i)));
endmodule

// File: tb/test_exc_entry_ctl.sv
`timescale 1ns/1ps
module test_exc_entry_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] msr_i = '0, pc_cur_i = '0, pc_next_i = '0;
  logic fex_i = 0, ue_i = 0, tiny_i = 0, fp_from_move_i = 0, step_i = 0;
  logic cmp_en_i = 0, cmp_exc_i = 0;
  logic [31:0] msr_o, srr0_o, srr1_o, vec_o;
  logic redirect_o, prog_req_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctl i_exc_entry_ctl (
    .clk(clk), .rst(rst), .msr_i(msr_i), .fex_i(fex_i), .ue_i(ue_i),
    .tiny_i(tiny_i), .fp_from_move_i(fp_from_move_i), .step_i(step_i),
    .cmp_en_i(cmp_en_i), .cmp_exc_i(cmp_exc_i), .pc_cur_i(pc_cur_i),
    .pc_next_i(pc_next_i), .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .redirect_o(redirect_o), .vec_o(vec_o), .prog_req_o(prog_req_o));

  logic [31:0] e_msr = 0, e_srr0 = 0, e_srr1 = 0, e_vec = 0;
  logic e_red = 0, e_prog = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " redirect R10"}, {31'b0, redirect_o}, {31'b0, e_red});
    chk({tag, " prog R3"}, {31'b0, prog_req_o}, {31'b0, e_prog});
    chk({tag, " vec R7"}, vec_o, e_vec);
    chk({tag, " msr R9"}, msr_o, e_msr);
    chk({tag, " srr0 R2 R5"}, srr0_o, e_srr0);
    chk({tag, " srr1 R8"}, srr1_o, e_srr1);
  endtask

  task automatic model_step();
    logic fpc, prog, assist, trace;
    fpc    = (msr_i[11] | msr_i[8]) & fex_i;
    prog   = fpc & fp_from_move_i;
    assist = !prog && (fpc || (tiny_i && !ue_i));
    trace  = !prog && !assist && step_i;
    e_prog = prog;
    e_red  = assist | trace;
    if (assist | trace) begin
      e_vec  = (msr_i[6] ? 32'hFFF0_0000 : 32'h0) + (assist ? 32'h0E00 : 32'h0D00);
      e_srr0 = assist ? pc_cur_i : pc_next_i;
      e_srr1 = {e_srr1[31], 4'b0, e_srr1[26:22], 6'b0, msr_i[15:0]};
      e_msr  = 32'h0;
      e_msr[0]  = msr_i[16];
      e_msr[6]  = msr_i[6];
      e_msr[12] = msr_i[12];
      e_msr[30] = cmp_en_i & cmp_exc_i;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("reset R1");
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] h;
      h = (i + 1) * 32'h9E37_79B9;
      h = h ^ (h >> 13);
      msr_i = h;
      msr_i[11] = i[0];
      msr_i[8]  = i[1];
      msr_i[6]  = i[7];
      fex_i = i[2]; ue_i = i[3]; tiny_i = i[4];
      fp_from_move_i = i[5]; step_i = i[6];
      cmp_en_i = i[8]; cmp_exc_i = i[9];
      pc_cur_i  = {h[29:0], 2'b00};
      pc_next_i = {h[29:0], 2'b00} + 32'd4;
      model_step();
      @(negedge clk);
      check_all("sweep R2 R4 R5 R6");
      msr_i = ~h; fex_i = 0; tiny_i = 0; step_i = 0; fp_from_move_i = 0;
      model_step();
      @(negedge clk);
      check_all("idle R10");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule